// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a synchronous memory port that supports four-beat bursts. When one of two start strobes is seen on a rising clock edge, it captures an external address and the order select. From then on the two least significant address bits come from an internal beat counter. The counter moves forward one beat on each edge where the advance input is high and holds when it is low. The upper address bits keep the value that was captured.

The beat sequence runs in one of two orders. In linear order the low bits are the starting low bits plus the beat number, modulo four. In interleaved order they are the starting low bits XOR the beat number. The block also reports the current beat number, a last-beat flag, and which strobe began the current burst.

Bursting is optional. Either strobe can load a fresh address on any cycle, with no extra cycles, and a load overrides any advance in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the next outputs are addr_out = 0, beat_pos = 0, beat_last = 0 and burst_src = 0.
- R2: A rising edge with strobe_proc or strobe_ctrl high makes addr_out equal addr_in and beat_pos equal 0 from the next cycle.
- R3: burst_src shows which strobe began the burst, 0 for processor and 1 for controller. When both strobes are high together, the processor strobe wins and burst_src = 0.
- R4: On an edge with no strobe and advance high, beat_pos increases by one, modulo 4.
- R5: On an edge with no strobe and advance low, addr_out, beat_pos and burst_src keep their values.
- R6: With linear order (order_sel = 0 at the load), addr_out[1:0] = (loaded low bits + beat_pos) mod 4.
- R7: With interleaved order (order_sel = 1 at the load), addr_out[1:0] = loaded low bits XOR beat_pos.
- R8: An advance after beat 3 returns beat_pos to 0. addr_out[ADDR_W-1:2] never changes except at a load, so there is no carry out of the low bits.
- R9: A strobe on the same edge as advance loads the new address and discards the step.
- R10: order_sel is used only at a load. Changing it during a burst does not change addr_out.
- R11: beat_last is 1 exactly when beat_pos is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External address captured at a load |
| strobe_proc | input | 1 | Processor-side burst start (higher priority) |
| strobe_ctrl | input | 1 | Controller-side burst start |
| advance | input | 1 | Step the beat counter |
| order_sel | input | 1 | 0 = linear, 1 = interleaved; sampled at a load |
| addr_out | output | ADDR_W | Current array address |
| beat_pos | output | 2 | Beat number within the burst |
| beat_last | output | 1 | High on the fourth beat |
| burst_src | output | 1 | Strobe that began the burst (1 = controller) |

## Verification
The in-RTL assertions check the following on every cycle:
- the counter is cleared by a load, steps on advance and holds otherwise;
- the upper address and the captured order stay the same between loads;
- the processor strobe wins when both strobes are high.

Only the bench's scenarios can show:
- the actual low-bit sequences for each starting offset in both orders, including the wrap;
- that a change of order_sel mid-burst has no effect on addr_out.

The bench checks these with a behavioural model that it compares against the outputs on every clock.

// File: rtl/bas_pkg.sv
// Shared types for the burst address sequencer.
// Assumes a burst of four beats, which gives a two-bit beat counter.
package bas_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } order_e;

    typedef enum logic {
        SRC_PROC = 1'b0,
        SRC_CTRL = 1'b1
    } src_e;
endpackage

// File: rtl/bas_load_reg.sv
// Load register: captures the address, the order and the strobe that
// started the burst. The processor strobe wins over the controller strobe.
// Assumes the strobes are synchronous to clk.
module bas_load_reg
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_in,
    output logic [ADDR_W-1:0] base_q,
    output order_e            order_q,
    output src_e              owner_q,
    output logic              load_o
);
    // A load happens when either strobe is present.
    assign load_o = strobe_proc | strobe_ctrl;

    // Capture the burst context on a load; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_LINEAR;
            owner_q <= SRC_PROC;
        end else if (load_o) begin
            base_q  <= addr_in;
            order_q <= order_e'(order_in);
            owner_q <= strobe_proc ? SRC_PROC : SRC_CTRL;
        end
    end

    // R3
    proc_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_proc |=> owner_q == SRC_PROC);
    // R10
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |=> $stable(order_q));
endmodule

// File: rtl/bas_beat_ctr.sv
// Beat counter: cleared by a load, steps on advance, and wraps modulo the
// burst length. Assumes a load takes priority over advance.
module bas_beat_ctr
    import bas_pkg::*;
#(
    parameter int CNT_W = BEAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] beat_q,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

    // Clear on load, step on advance, wrap naturally at the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (load_i)  beat_q <= '0;
        else if (adv_i)   beat_q <= beat_q + 1'b1;
    end

    // Flag the final beat of the group.
    assign last_o = (beat_q == LAST_BEAT);

    // R2 R9
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_q == '0);
    // R4 R8
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i) |=> beat_q == CNT_W'($past(beat_q) + 1'b1));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(beat_q));
endmodule

// File: rtl/bas_order_map.sv
// Order map: turns the starting low bits and the beat number into the
// low address bits, in linear (sum) or interleaved (XOR) order.
// Purely combinational. Assumes order_i is already held for the burst.
module bas_order_map
    import bas_pkg::*;
#(
    parameter int CNT_W = BEAT_W
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [CNT_W-1:0] low_o
);
    logic [CNT_W-1:0] lin_w;
    logic [CNT_W-1:0] ilv_w;

    // Linear order: sum truncated to the counter width.
    assign lin_w = start_i + beat_i;

    // Interleaved order: bitwise XOR, one gate per bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_w[b] = start_i[b] ^ beat_i[b];
    end

    // Pick the variant that was captured at the load.
    always_comb begin
        low_o = (order_i == ORD_INTLV) ? ilv_w : lin_w;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top. It captures a base address on either start
// strobe, then produces the four-beat low-bit sequence in the order chosen
// at the load. The upper bits never receive a carry.
// Assumes all inputs are synchronous to clk and that ADDR_W > BEAT_W.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_pos,
    output logic              beat_last,
    output logic              burst_src
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_w;
    order_e            order_w;
    src_e              owner_w;
    logic              load_w;
    logic [BEAT_W-1:0] beat_w;
    logic [BEAT_W-1:0] low_w;

    bas_load_reg #(.ADDR_W(ADDR_W)) load_i (
        .clk(clk), .rst_n(rst_n),
        .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
        .addr_in(addr_in), .order_in(order_sel),
        .base_q(base_w), .order_q(order_w), .owner_q(owner_w),
        .load_o(load_w)
    );

    bas_beat_ctr #(.CNT_W(BEAT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n),
        .load_i(load_w), .adv_i(advance),
        .beat_q(beat_w), .last_o(beat_last)
    );

    bas_order_map #(.CNT_W(BEAT_W)) map_i (
        .start_i(base_w[BEAT_W-1:0]), .beat_i(beat_w),
        .order_i(order_w), .low_o(low_w)
    );

    // Join the held upper bits with the mapped low bits.
    assign addr_out  = {base_w[ADDR_W-1:BEAT_W], low_w};
    assign beat_pos  = beat_w;
    assign burst_src = owner_w;

    // R8
    no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));
    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> addr_out == $past(addr_in));
    // R3
    ctrl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctrl && !strobe_proc) |=> burst_src == 1'b1);
    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && !advance) |=> $stable(addr_out) && $stable(burst_src));
    // R8
    up_width_chk: assert final (UP_W > 0);
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_proc = 1'b0, strobe_ctrl = 1'b0, advance = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_pos;
    logic          beat_last, burst_src;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    int m_base = 0, m_beat = 0, m_mode = 0, m_src = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
        .advance(advance), .order_sel(order_sel),
        .addr_out(addr_out), .beat_pos(beat_pos),
        .beat_last(beat_last), .burst_src(burst_src)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_addr();
        int lo;
        lo = m_base & 3;
        lo = m_mode ? (lo ^ m_beat) : ((lo + m_beat) % 4);
        return (m_base & ~3) | lo;
    endfunction

    // Model update at the edge, then comparison shortly after it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_beat = 0; m_mode = 0; m_src = 0;
        end else if (strobe_proc || strobe_ctrl) begin
            m_base = int'(addr_in); m_beat = 0; m_mode = int'(order_sel);
            m_src = strobe_proc ? 0 : 1;
        end else if (advance) begin
            m_beat = (m_beat + 1) % 4;
        end
        #1;
        chk(m_mode ? "R7 addr" : "R6 addr", int'(addr_out), exp_addr());
        chk("R4 beat", int'(beat_pos), m_beat);
        chk("R3 src", int'(burst_src), m_src);
        chk("R11 last", int'(beat_last), (m_beat == 3) ? 1 : 0);
    end

    task automatic step(input logic p, input logic c, input logic a,
                        input logic o, input logic [AW-1:0] ad);
        @(negedge clk);
        strobe_proc = p; strobe_ctrl = c; advance = a; order_sel = o; addr_in = ad;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(0, 0, 0, 0, 20'hFFFFF);
        step(1, 1, 1, 1, 20'hFFFFF);
        // R1: reset state
        chk("R1 addr", int'(addr_out), 0);
        chk("R1 beat", int'(beat_pos), 0);
        chk("R1 src", int'(burst_src), 0);
        chk("R1 last", int'(beat_last), 0);
        rst_n = 1'b1;

        // R2 and R6: linear load from offset 3, then wrap (R8)
        step(1, 0, 0, 0, 20'h12347);
        chk("R2 load", int'(addr_out), 'h12347);
        step(0, 0, 1, 0, 20'h0); chk("R6 lin1", int'(addr_out), 'h12344);
        step(0, 0, 1, 0, 20'h0); chk("R6 lin2", int'(addr_out), 'h12345);
        step(0, 0, 1, 0, 20'h0); chk("R6 lin3", int'(addr_out), 'h12346);
        chk("R11 last", int'(beat_last), 1);
        step(0, 0, 1, 0, 20'h0); chk("R8 wrap", int'(addr_out), 'h12347);
        chk("R8 beat0", int'(beat_pos), 0);

        // R7 and R10: interleaved from offset 2; toggling order_sel mid-burst
        step(0, 1, 0, 1, 20'hABCD2);
        chk("R3 ctrl", int'(burst_src), 1);
        step(0, 0, 1, 0, 20'h0); chk("R10 ilv1", int'(addr_out), 'hABCD3);
        step(0, 0, 1, 1, 20'h0); chk("R7 ilv2", int'(addr_out), 'hABCD0);
        step(0, 0, 1, 0, 20'h0); chk("R7 ilv3", int'(addr_out), 'hABCD1);

        // R5: hold with no advance
        step(0, 0, 0, 0, 20'h55555); chk("R5 hold", int'(addr_out), 'hABCD1);
        chk("R5 beat", int'(beat_pos), 3);

        // R3: both strobes, processor wins; R9: strobe beats advance
        step(1, 1, 1, 0, 20'h00011);
        chk("R3 both", int'(burst_src), 0);
        chk("R9 beat", int'(beat_pos), 0);
        chk("R9 addr", int'(addr_out), 'h00011);

        // Random traffic compared against the model every clock.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) == 0, ($urandom % 6) == 0, $urandom % 2,
                 $urandom % 2, AW'($urandom));
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule